// File: doc/BRIEF.md
# Oversampling Serial Receiver with Tagged Character Queue

This block is the receive side of a fixed-format asynchronous serial port. A programmable divider turns the core clock into a base tick, and every bit on the line lasts fourteen of those ticks. A bit engine hunts for start bits, confirms them at mid-bit and assembles characters of eight data bits, no parity and one stop bit. Each finished character is written into a 64-entry queue together with a framing-error flag and a break flag.

The consumer drains the queue through a valid/ready stream. `out_valid` is high whenever the queue holds at least one character, and a character leaves the queue on each rising clock edge where `out_valid` and `out_ready` are both high. There is no back-pressure towards the line: a character that arrives while the queue is full is lost and reported. Status flows out on plain pins: the fill level, a trigger request chosen from a six-step threshold table, an inactivity timeout counted in whole character times, and one-cycle pulses for framing error, break and overrun.

Top module: `srx_tagged_rx`

## Requirements
- R1: Characters are 8N1. The data bits are received LSB first and appear in `out_word[7:0]`.
- R2: The base tick fires once every `rate_div`+1 clocks, and one bit lasts 14 ticks. A character sent at that bit period is received correctly for any `rate_div`.
- R3: A start bit is accepted only if the line is still low 7 ticks after the falling edge. A shorter low pulse produces no character.
- R4: The queue holds up to 64 characters in arrival order, and `rx_level` gives the current number of entries.
- R5: The head word is {break, framing error, empty, data}: bit 10 is break, bit 9 is framing error, bit 8 is empty. When the queue is empty the word reads 0x100.
- R6: A character is removed when `out_valid` and `out_ready` are both high at a rising edge. `out_ready` while the queue is empty is ignored, and the level stays 0.
- R7: A stop bit sampled low sets bit 9 on that character and pulses `fe_evt` for one cycle when the character is stored.
- R8: An all-zero character with a low stop bit sets both bits 10 and 9 and pulses `brk_evt` and `fe_evt`. The receiver then waits for the line to return high, so a long break yields exactly one entry.
- R9: A character that arrives while the queue holds 64 entries is dropped. `ovr_evt` pulses and the level stays at 64.
- R10: `trig_evt` is high while the level is at least the threshold selected by `trig_sel`: codes 0 to 5 give 1, 4, 8, 16, 32, 48 characters, and codes 6 and 7 give 48.
- R11: `tmo_sel` codes 1, 2, 3 select 4, 8, 16 character times, where one character time is 140 ticks. `tmo_evt` is high while the queue is not empty and the receiver has been idle with no new character for at least that long. Code 0 keeps it low.
- R12: After reset the queue is empty, `out_valid`, `trig_evt` and `tmo_evt` are low, and the line is assumed idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| rate_div | input | 8 | Tick divider: a tick every rate_div+1 clocks |
| trig_sel | input | 3 | Trigger threshold code |
| tmo_sel | input | 2 | Timeout length code |
| out_valid | output | 1 | Queue holds a character |
| out_ready | input | 1 | Consumer takes the head character |
| out_word | output | 11 | Tagged head word |
| rx_level | output | 8 | Number of queued characters |
| trig_evt | output | 1 | Level at or above the trigger threshold |
| tmo_evt | output | 1 | Inactivity timeout with data pending |
| fe_evt | output | 1 | One-cycle pulse: stored character had a bad stop bit |
| brk_evt | output | 1 | One-cycle pulse: stored character was a break |
| ovr_evt | output | 1 | One-cycle pulse: character dropped, queue full |

## Verification
The bench fills the queue to exactly 64 entries and sends one more character. A design with an off-by-one full test would either keep the extra character or drop the 64th, and the drained sequence or the overrun count exposes both. A held-low break must give a single tagged entry; a receiver that restarts on the still-low line would queue a run of spurious breaks. A three-clock glitch must be rejected, which catches a receiver that skips the mid-bit confirmation of the start bit. The timeout is probed just below and just above four character times, so a limit counted in bits instead of characters fails, and a slower divider setting catches a tick that is off by one clock.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned OVS        = 14;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = 10;

  typedef struct packed {
    logic                 brk;
    logic                 fe;
    logic [DATA_BITS-1:0] data;
  } srx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_STOP, S_HOLD
  } srx_state_t;

  function automatic int unsigned trig_threshold(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int unsigned tmo_chars(input logic [1:0] code);
    case (code)
      2'd1:    return 4;
      2'd2:    return 8;
      2'd3:    return 16;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_div,
  output logic              tick
);
  logic [RATE_W-1:0] cnt_q;

  assign tick = (cnt_q >= rate_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/srx_bit_engine.sv
module srx_bit_engine
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       push,
  output srx_entry_t push_entry,
  output logic       busy
);
  localparam int SUB_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [SUB_W-1:0] START_CHK = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] BIT_END   = SUB_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(DATA_BITS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  srx_state_t             state_q;
  logic [SUB_W-1:0]       sub_q;
  logic [IDX_W-1:0]       idx_q;
  logic [DATA_BITS-1:0]   shift_q;

  assign rx_s = sync_q[SYNC_STAGES-1];
  assign busy = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      sub_q      <= '0;
      idx_q      <= '0;
      shift_q    <= '0;
      push       <= 1'b0;
      push_entry <= '0;
    end else begin
      push <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (tick && !rx_s) begin
            state_q <= S_START;
            sub_q   <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (sub_q == START_CHK) begin
              sub_q   <= '0;
              idx_q   <= '0;
              state_q <= rx_s ? S_IDLE : S_DATA;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (tick) begin
            if (sub_q == BIT_END) begin
              sub_q   <= '0;
              shift_q <= {rx_s, shift_q[DATA_BITS-1:1]};
              if (idx_q == LAST_BIT) state_q <= S_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
        end
        S_STOP: begin
          if (tick) begin
            if (sub_q == BIT_END) begin
              sub_q           <= '0;
              push            <= 1'b1;
              push_entry.data <= shift_q;
              push_entry.fe   <= !rx_s;
              push_entry.brk  <= !rx_s && (shift_q == '0);
              state_q         <= rx_s ? S_IDLE : S_HOLD;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
        end
        S_HOLD: begin
          if (rx_s) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  srx_entry_t       push_entry,
  input  logic             pop,
  output srx_entry_t       head,
  output logic [CNT_W-1:0] count,
  output logic             overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  srx_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != FULL_CNT);
  assign pop_ok  = pop && (count != '0);
  assign overrun = push && (count == FULL_CNT);
  assign head    = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/srx_events.sv
module srx_events
  import srx_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int TMO_W = $clog2(16 * OVS * FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             busy,
  input  logic             push,
  input  logic [CNT_W-1:0] count,
  input  logic [2:0]       trig_sel,
  input  logic [1:0]       tmo_sel,
  output logic             trig,
  output logic             tmo
);
  localparam logic [TMO_W-1:0] IDLE_MAX = '1;

  logic [TMO_W-1:0] idle_q;
  logic [TMO_W-1:0] limit;
  logic [CNT_W-1:0] thresh;

  assign thresh = CNT_W'(trig_threshold(trig_sel));
  assign limit  = TMO_W'(tmo_chars(tmo_sel) * OVS * FRAME_BITS);
  assign trig   = (count >= thresh);
  assign tmo    = (tmo_sel != 2'd0) && (count != '0) && (idle_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             idle_q <= '0;
    else if (busy || push)                  idle_q <= '0;
    else if (tick && (idle_q != IDLE_MAX))  idle_q <= idle_q + 1'b1;
  end
endmodule

// File: rtl/srx_tagged_rx.sv
module srx_tagged_rx
  import srx_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int RATE_W      = 8,
  parameter int LEVEL_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxd,
  input  logic [RATE_W-1:0]  rate_div,
  input  logic [2:0]         trig_sel,
  input  logic [1:0]         tmo_sel,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [10:0]        out_word,
  output logic [LEVEL_W-1:0] rx_level,
  output logic               trig_evt,
  output logic               tmo_evt,
  output logic               fe_evt,
  output logic               brk_evt,
  output logic               ovr_evt
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             tick, busy, push;
  srx_entry_t       push_entry, head;
  logic [CNT_W-1:0] count;

  srx_tick_gen #(.RATE_W(RATE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .rate_div(rate_div), .tick(tick)
  );

  srx_bit_engine #(.SYNC_STAGES(SYNC_STAGES)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .push(push), .push_entry(push_entry), .busy(busy)
  );

  srx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_entry(push_entry),
    .pop(out_ready), .head(head), .count(count), .overrun(ovr_evt)
  );

  srx_events #(.CNT_W(CNT_W)) u_events (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .push(push),
    .count(count), .trig_sel(trig_sel), .tmo_sel(tmo_sel),
    .trig(trig_evt), .tmo(tmo_evt)
  );

  assign out_valid = (count != '0);
  assign out_word  = out_valid ? {head.brk, head.fe, 1'b0, head.data}
                               : 11'h100;
  assign rx_level  = LEVEL_W'(count);
  assign fe_evt    = push && push_entry.fe;
  assign brk_evt   = push && push_entry.brk;
endmodule

// File: rtl/srx_tagged_rx_chk.sv
module srx_tagged_rx_chk #(
  parameter int DEPTH   = 64,
  parameter int LEVEL_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic [10:0]        out_word,
  input logic [LEVEL_W-1:0] rx_level,
  input logic [2:0]         trig_sel,
  input logic [1:0]         tmo_sel,
  input logic               trig_evt,
  input logic               tmo_evt,
  input logic               fe_evt,
  input logic               brk_evt,
  input logic               ovr_evt
);
  localparam logic [LEVEL_W-1:0] FULL_LVL = LEVEL_W'(DEPTH);
  localparam logic [LEVEL_W-1:0] ONE_LVL  = LEVEL_W'(1);

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= FULL_LVL);
  // R6
  valid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (rx_level != '0));
  // R5
  empty_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_word == 11'h100);
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready) |=> rx_level <= ONE_LVL);
  // R7
  fe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_evt |=> !fe_evt);
  // R8
  brk_implies_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> fe_evt);
  // R9
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> rx_level == FULL_LVL);
  // R10
  trig_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == 3'd0) |-> (trig_evt == out_valid));
  // R11
  tmo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sel == 2'd0) |-> !tmo_evt);
endmodule

bind srx_tagged_rx srx_tagged_rx_chk #(.DEPTH(DEPTH), .LEVEL_W(LEVEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .rx_level(rx_level), .trig_sel(trig_sel),
  .tmo_sel(tmo_sel), .trig_evt(trig_evt), .tmo_evt(tmo_evt),
  .fe_evt(fe_evt), .brk_evt(brk_evt), .ovr_evt(ovr_evt)
);

// File: tb/srx_tagged_rx_bench.sv
module srx_tagged_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [7:0]  rate_div = 8'd0;
  logic [2:0]  trig_sel = 3'd0;
  logic [1:0]  tmo_sel = 2'd0;
  logic        out_ready = 1'b0;
  logic        out_valid, trig_evt, tmo_evt, fe_evt, brk_evt, ovr_evt;
  logic [10:0] out_word;
  logic [7:0]  rx_level;

  int errors = 0;
  int checks = 0;
  int fe_seen = 0, brk_seen = 0, ovr_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  srx_tagged_rx u_srx_tagged_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rate_div(rate_div),
    .trig_sel(trig_sel), .tmo_sel(tmo_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .rx_level(rx_level),
    .trig_evt(trig_evt), .tmo_evt(tmo_evt), .fe_evt(fe_evt),
    .brk_evt(brk_evt), .ovr_evt(ovr_evt)
  );

  always @(negedge clk) begin
    if (fe_evt)  fe_seen++;
    if (brk_evt) brk_seen++;
    if (ovr_evt) ovr_seen++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] d, input logic stop_bit);
    int bit_clks = 14 * (int'(rate_div) + 1);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bit_clks) @(negedge clk);
    end
    rxd = stop_bit;
    repeat (bit_clks) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic pop_word(output logic [10:0] w);
    @(negedge clk);
    w = out_word;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic drain();
    logic [10:0] w;
    while (out_valid) pop_word(w);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 valid after reset", out_valid, 0);
    chk("R12 level after reset", rx_level, 0);
    chk("R12 trig after reset", trig_evt, 0);
    chk("R12 tmo after reset", tmo_evt, 0);
    chk("R5 empty word", out_word, 11'h100);
  endtask

  task automatic t_basic();
    logic [10:0] w;
    send_char(8'hA5, 1'b1);
    repeat (4) @(negedge clk);
    chk("R4 level one char", rx_level, 1);
    chk("R1 data A5", out_word, 11'h0A5);
    pop_word(w);
    chk("R6 level after pop", rx_level, 0);
    chk("R6 valid after pop", out_valid, 0);
  endtask

  task automatic t_order();
    logic [10:0] w;
    send_char(8'h00, 1'b1);
    send_char(8'hFF, 1'b1);
    send_char(8'h3C, 1'b1);
    repeat (4) @(negedge clk);
    chk("R4 level three", rx_level, 3);
    pop_word(w); chk("R1 R4 first 00", w, 11'h000);
    pop_word(w); chk("R1 R4 second FF", w, 11'h0FF);
    pop_word(w); chk("R1 R4 third 3C", w, 11'h03C);
  endtask

  task automatic t_empty_pop();
    repeat (3) begin
      @(negedge clk);
      out_ready = 1'b1;
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk("R6 level after empty pops", rx_level, 0);
    chk("R6 R5 word after empty pops", out_word, 11'h100);
  endtask

  task automatic t_framing();
    logic [10:0] w;
    int fe0 = fe_seen, brk0 = brk_seen;
    send_char(8'h5A, 1'b0);
    repeat (4) @(negedge clk);
    chk("R7 level", rx_level, 1);
    chk("R7 fe pulse count", fe_seen - fe0, 1);
    chk("R7 no brk pulse", brk_seen - brk0, 0);
    pop_word(w);
    chk("R7 framing word", w, 11'h25A);
  endtask

  task automatic t_break();
    logic [10:0] w;
    int fe0 = fe_seen, brk0 = brk_seen;
    send_char(8'h00, 1'b0);
    rxd = 1'b0;
    repeat (60) @(negedge clk);
    rxd = 1'b1;
    repeat (60) @(negedge clk);
    chk("R8 single entry", rx_level, 1);
    chk("R8 brk pulse count", brk_seen - brk0, 1);
    chk("R8 fe pulse count", fe_seen - fe0, 1);
    pop_word(w);
    chk("R8 break word", w, 11'h600);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    chk("R3 glitch rejected", rx_level, 0);
  endtask

  task automatic t_rate();
    logic [10:0] w;
    rate_div = 8'd2;
    repeat (10) @(negedge clk);
    send_char(8'h96, 1'b1);
    repeat (10) @(negedge clk);
    chk("R2 level at slow rate", rx_level, 1);
    pop_word(w);
    chk("R2 data at slow rate", w, 11'h096);
    rate_div = 8'd0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_trigger();
    trig_sel = 3'd1;
    for (int i = 0; i < 3; i++) send_char(8'h11, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 below 4", trig_evt, 0);
    send_char(8'h11, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 at 4", trig_evt, 1);
    trig_sel = 3'd5;
    @(negedge clk);
    chk("R10 code5 with 4", trig_evt, 0);
    trig_sel = 3'd2;
    @(negedge clk);
    chk("R10 code2 with 4", trig_evt, 0);
    drain();
    trig_sel = 3'd0;
  endtask

  task automatic t_overrun();
    logic [10:0] w;
    int ovr0 = ovr_seen;
    int bad = 0;
    trig_sel = 3'd5;
    for (int i = 1; i <= 48; i++) send_char(8'(i), 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 at 48", trig_evt, 1);
    for (int i = 49; i <= 64; i++) send_char(8'(i), 1'b1);
    repeat (4) @(negedge clk);
    chk("R4 full level", rx_level, 64);
    chk("R9 no overrun yet", ovr_seen - ovr0, 0);
    send_char(8'hEE, 1'b1);
    repeat (4) @(negedge clk);
    chk("R9 level stays 64", rx_level, 64);
    chk("R9 overrun pulse", ovr_seen - ovr0, 1);
    for (int i = 1; i <= 64; i++) begin
      pop_word(w);
      if (w != {3'b000, 8'(i)}) bad++;
    end
    chk("R9 R4 drained sequence mismatches", bad, 0);
    chk("R9 empty after drain", out_valid, 0);
    trig_sel = 3'd0;
  endtask

  task automatic t_timeout();
    tmo_sel = 2'd1;
    send_char(8'h42, 1'b1);
    repeat (540) @(negedge clk);
    chk("R11 before 4 chars", tmo_evt, 0);
    repeat (40) @(negedge clk);
    chk("R11 after 4 chars", tmo_evt, 1);
    tmo_sel = 2'd0;
    @(negedge clk);
    chk("R11 disabled", tmo_evt, 0);
    tmo_sel = 2'd1;
    drain();
    @(negedge clk);
    chk("R11 empty queue", tmo_evt, 0);
    tmo_sel = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_order();
    t_empty_pop();
    t_framing();
    t_break();
    t_glitch();
    t_rate();
    t_trigger();
    t_timeout();
    t_overrun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule